// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches up to four external input pins and raises one interrupt line per pin when the configured trigger condition occurs. Each channel can fire on a rising edge, a falling edge, either edge, a high level or a low level. Every pin passes through a two-stage synchronizer before any decision is taken, so the pins may be fully asynchronous to the block clock.

All per-channel control and status bits sit in one 32-bit register reached through a minimal bus port: address, write enable, write data and combinational read data. The register is split into six fields of `FIELD_W` bits each. In each field, bit n belongs to channel n. The order of the fields is fixed because software composes words against it. A build-time parameter chooses how the clear bit behaves. In the default pulse mode a written 1 acknowledges the channel once and then falls back to 0 by itself. In held mode the written value stays in place, and while it is 1 the channel is kept silent.

Top module: `extirq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every register bit reads 0 and all interrupt outputs are 0. This means every channel starts masked, in falling-edge mode.
- R2: The bit for channel n in field k is at position n + k*FIELD_W, with FIELD_W = 4 by default. The fields, from the least significant end, are: 0 = polarity (sense), 1 = status, 2 = clear, 3 = mask, 4 = any-edge, 5 = level-select. Written sense, mask, any-edge and level-select bits read back at those positions.
- R3: With level-select 0, any-edge 0 and sense 1, a rising edge on the synchronized pin sets the sticky status bit. A falling edge does not set it.
- R4: With level-select 0, any-edge 0 and sense 0, a falling edge sets the sticky status bit. A rising edge does not set it.
- R5: With level-select 0 and any-edge 1, either edge sets the sticky status bit, whatever the sense bit holds.
- R6: With level-select 1, the status bit follows the pin every cycle. It is 1 while the pin equals the sense bit (1 = high active, 0 = low active) and 0 otherwise.
- R7: Interrupt output n is the registered value of status AND mask for channel n. After a pin change, status becomes visible on the third clock edge and the interrupt on the fourth. A channel whose mask bit is 0 never raises its interrupt.
- R8: The status field is read-only. Writing to it changes nothing.
- R9: In pulse mode, writing 1 to a channel's clear bit clears its sticky status on the next clock edge. The clear bit reads 1 for exactly one cycle after the write and then reads 0.
- R10: In pulse mode, if a trigger edge is detected in the same cycle that a clear takes effect, the edge wins and the status stays 1.
- R11: In held mode, the clear bit keeps the value written to it. While it is 1, the channel's status stays 0 and its interrupt stays 0, even when trigger edges arrive. After a 0 is written to it, the channel triggers again.
- R12: Register bits at positions 6*FIELD_W and above always read 0. Addresses other than 0 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address; only 0 holds the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| ext_pin | input | NUM_CH | Asynchronous external pins |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
A wrong trigger decode or a missing synchronizer stage shows up as a status bit in the read word that is wrong, or that appears one cycle early or late, relative to the third edge after a pin change. The interrupt line then lags that status by exactly one more edge. A clear bit that does not fall back in pulse mode is visible in the read word on the very next cycle. In held mode, a channel that is not properly suppressed shows a status bit of 1 within three edges of a pin toggle. A mis-packed field appears at once in the read word as a bit at the wrong position.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;

    localparam int NUM_FIELDS = 6;

    // Field order is fixed: software builds words against it.
    typedef enum logic [2:0] {
        FLD_SENSE  = 3'd0,
        FLD_STATUS = 3'd1,
        FLD_CLEAR  = 3'd2,
        FLD_MASK   = 3'd3,
        FLD_ANY    = 3'd4,
        FLD_LEVEL  = 3'd5
    } field_e;

    typedef struct packed {
        logic level;
        logic sense;
        logic any_edge;
    } trig_cfg_t;

    typedef enum logic [1:0] {
        TRIG_RISE,
        TRIG_FALL,
        TRIG_ANY,
        TRIG_LEVEL
    } trig_kind_e;

    function automatic trig_kind_e decode_trig(trig_cfg_t c);
        if (c.level)
            return TRIG_LEVEL;
        else if (c.any_edge)
            return TRIG_ANY;
        else if (c.sense)
            return TRIG_RISE;
        else
            return TRIG_FALL;
    endfunction

    function automatic int bit_pos(int ch, field_e f, int fw);
        return ch + int'(f) * fw;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/1ps
module extirq_sync #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_async,
    output logic [NUM_CH-1:0] pin_now,
    output logic [NUM_CH-1:0] pin_prev
);

    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] now_q;
    logic [NUM_CH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    assign pin_now  = now_q;
    assign pin_prev = prev_q;

endmodule

// File: rtl/extirq_chan.sv
`timescale 1ns/1ps
module extirq_chan
    import extirq_pkg::*;
#(
    parameter bit HOLD_CLEAR = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_now,
    input  logic      pin_prev,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      status
);

    trig_kind_e kind;
    logic       rise;
    logic       fall;
    logic       hit;
    logic       level_on;
    logic       status_q;

    always_comb begin
        kind     = decode_trig(cfg);
        rise     = pin_now & ~pin_prev;
        fall     = ~pin_now & pin_prev;
        level_on = (pin_now == cfg.sense);
        unique case (kind)
            TRIG_RISE:  hit = rise;
            TRIG_FALL:  hit = fall;
            TRIG_ANY:   hit = rise | fall;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else if (HOLD_CLEAR && clr)
            status_q <= 1'b0;
        else if (kind == TRIG_LEVEL)
            status_q <= level_on;
        else if (hit)
            status_q <= 1'b1;      // a fresh edge beats a same-cycle clear
        else if (clr)
            status_q <= 1'b0;
    end

    assign status = status_q;

endmodule

// File: rtl/extirq_regs.sv
`timescale 1ns/1ps
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int FIELD_W    = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter bit HOLD_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] sense_q,
    output logic [NUM_CH-1:0] any_q,
    output logic [NUM_CH-1:0] level_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] clr_q
);

    localparam int USED_W = NUM_FIELDS * FIELD_W;

    logic              sel;
    logic              wr_hit;
    logic [DATA_W-1:0] word;

    assign sel    = (bus_addr == '0);
    assign wr_hit = bus_wr && sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            any_q   <= '0;
            level_q <= '0;
            mask_q  <= '0;
            clr_q   <= '0;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (wr_hit) begin
                    sense_q[n] <= bus_wdata[bit_pos(n, FLD_SENSE, FIELD_W)];
                    any_q[n]   <= bus_wdata[bit_pos(n, FLD_ANY, FIELD_W)];
                    level_q[n] <= bus_wdata[bit_pos(n, FLD_LEVEL, FIELD_W)];
                    mask_q[n]  <= bus_wdata[bit_pos(n, FLD_MASK, FIELD_W)];
                    clr_q[n]   <= bus_wdata[bit_pos(n, FLD_CLEAR, FIELD_W)];
                end else if (!HOLD_CLEAR) begin
                    clr_q[n]   <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        word = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            word[bit_pos(n, FLD_SENSE, FIELD_W)]  = sense_q[n];
            word[bit_pos(n, FLD_STATUS, FIELD_W)] = status[n];
            word[bit_pos(n, FLD_CLEAR, FIELD_W)]  = clr_q[n];
            word[bit_pos(n, FLD_MASK, FIELD_W)]   = mask_q[n];
            word[bit_pos(n, FLD_ANY, FIELD_W)]    = any_q[n];
            word[bit_pos(n, FLD_LEVEL, FIELD_W)]  = level_q[n];
        end
        bus_rdata = sel ? word : '0;
    end

endmodule

// File: rtl/extirq_ctrl.sv
`timescale 1ns/1ps
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int FIELD_W    = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter bit HOLD_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ext_pin,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] pin_now;
    logic [NUM_CH-1:0] pin_prev;
    logic [NUM_CH-1:0] stat_q;
    logic [NUM_CH-1:0] sense_q;
    logic [NUM_CH-1:0] any_q;
    logic [NUM_CH-1:0] level_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] clr_q;
    logic [NUM_CH-1:0] gate;
    logic [NUM_CH-1:0] irq_q;

    extirq_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_pin),
        .pin_now   (pin_now),
        .pin_prev  (pin_prev)
    );

    extirq_regs #(
        .NUM_CH     (NUM_CH),
        .FIELD_W    (FIELD_W),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .HOLD_CLEAR (HOLD_CLEAR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (stat_q),
        .sense_q   (sense_q),
        .any_q     (any_q),
        .level_q   (level_q),
        .mask_q    (mask_q),
        .clr_q     (clr_q)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        trig_cfg_t cfg;
        assign cfg = '{level: level_q[n], sense: sense_q[n], any_edge: any_q[n]};

        extirq_chan #(.HOLD_CLEAR(HOLD_CLEAR)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .pin_now  (pin_now[n]),
            .pin_prev (pin_prev[n]),
            .cfg      (cfg),
            .clr      (clr_q[n]),
            .status   (stat_q[n])
        );
    end

    if (HOLD_CLEAR) begin : g_hold_gate
        assign gate = mask_q & ~clr_q;
    end else begin : g_pulse_gate
        assign gate = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= '0;
        else
            irq_q <= stat_q & gate;
    end

    assign irq = irq_q;

endmodule

// File: rtl/extirq_ctrl_chk.sv
`timescale 1ns/1ps
module extirq_ctrl_chk #(
    parameter int NUM_CH     = 4,
    parameter int FIELD_W    = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter bit HOLD_CLEAR = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] stat_vec,
    input logic [NUM_CH-1:0] mask_vec,
    input logic [NUM_CH-1:0] clr_vec
);

    localparam int USED_W = 6 * FIELD_W;

    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == '0);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (irq == '0));

    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~$past(mask_vec)) == '0));

    assert_pulse_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (!HOLD_CLEAR && !$past(wr_hit)) |-> (clr_vec == '0));

    assert_held_clear_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        HOLD_CLEAR |-> ((stat_vec & $past(clr_vec)) == '0));

    assert_other_addr_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != '0) |-> (bus_rdata == '0));

    if (USED_W < DATA_W) begin : g_upper
        assert_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
            (bus_rdata[DATA_W-1:USED_W] == '0));
    end

endmodule

bind extirq_ctrl extirq_ctrl_chk #(
    .NUM_CH     (NUM_CH),
    .FIELD_W    (FIELD_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .HOLD_CLEAR (HOLD_CLEAR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat_vec  (stat_q),
    .mask_vec  (mask_q),
    .clr_vec   (clr_q)
);

// File: tb/extirq_ctrl_bench.sv
`timescale 1ns/1ps
module extirq_ctrl_bench;

    localparam int NCH = 4;
    localparam int FW  = 4;
    localparam int DW  = 32;
    localparam int AW  = 2;

    // {level, sense, any, pin_before, pin_after, expected_status}
    localparam logic [5:0] VEC [10] = '{
        6'b010_01_1, 6'b010_10_0,   // rising       R3
        6'b000_10_1, 6'b000_01_0,   // falling      R4
        6'b001_01_1, 6'b011_10_1,   // any edge     R5
        6'b110_01_1, 6'b110_10_0,   // level high   R6
        6'b100_10_1, 6'b100_01_0    // level low    R6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_p = 1'b0;
    logic          wr_h = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NCH-1:0] pins_p = '0;
    logic [NCH-1:0] pins_h = '0;
    logic [DW-1:0] rd_p;
    logic [DW-1:0] rd_h;
    logic [NCH-1:0] irq_p;
    logic [NCH-1:0] irq_h;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    extirq_ctrl #(.NUM_CH(NCH), .FIELD_W(FW), .DATA_W(DW), .ADDR_W(AW), .HOLD_CLEAR(1'b0)) u_extirq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(wr_p), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_p), .ext_pin(pins_p), .irq(irq_p)
    );

    extirq_ctrl #(.NUM_CH(NCH), .FIELD_W(FW), .DATA_W(DW), .ADDR_W(AW), .HOLD_CLEAR(1'b1)) u_extirq_ctrl_held (
        .clk(clk), .rst(rst), .bus_wr(wr_h), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_h), .ext_pin(pins_h), .irq(irq_h)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] cfgw(int ch, bit lvl, bit sen, bit any, bit msk, bit clr);
        logic [DW-1:0] w = '0;
        w[ch + 0*FW] = sen;
        w[ch + 2*FW] = clr;
        w[ch + 3*FW] = msk;
        w[ch + 4*FW] = any;
        w[ch + 5*FW] = lvl;
        return w;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_pulse(logic [DW-1:0] d);
        wdata = d; wr_p = 1'b1;
        @(negedge clk);
        wr_p = 1'b0;
    endtask

    task automatic wr_held(logic [DW-1:0] d);
        wdata = d; wr_h = 1'b1;
        @(negedge clk);
        wr_h = 1'b0;
    endtask

    function automatic logic stat_bit(logic [DW-1:0] r, int ch);
        return r[ch + FW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 reg in reset", rd_p, '0);
        check("R1 irq in reset", {28'h0, irq_p}, '0);
        rst = 1'b0;
        cyc(2);
        check("R1 reg after reset", rd_p, '0);
        check("R1 irq after reset", {28'h0, irq_p}, '0);

        // status field read-only, upper bits zero
        wr_pulse(32'hFF00_00F0);
        check("R8 status write ignored", rd_p, '0);
        check("R12 upper bits zero", rd_p & 32'hFF00_0000, '0);

        // other address ignored
        addr = 2'd1;
        wr_pulse(32'h0000_F000);
        check("R12 other addr reads zero", rd_p, '0);
        addr = 2'd0;
        check("R12 other addr write ignored", rd_p, '0);

        // vector table, channel 0
        for (int i = 0; i < 10; i++) begin
            logic [5:0] v;
            v = VEC[i];
            wr_pulse(cfgw(0, v[5], v[4], v[3], 1'b1, 1'b0));
            pins_p[0] = v[2];
            cyc(6);
            wr_pulse(cfgw(0, v[5], v[4], v[3], 1'b1, 1'b1));
            cyc(2);
            pins_p[0] = v[1];
            cyc(6);
            check($sformatf("R3/R4/R5/R6 vec%0d status", i), {31'h0, stat_bit(rd_p, 0)}, {31'h0, v[0]});
            check($sformatf("R7 vec%0d irq", i), {31'h0, irq_p[0]}, {31'h0, v[0]});
        end
        // leave channel 0 idle: falling mode, masked; its pin stays high

        // R2 packing: ch3 level-high masked on, ch1 any-edge masked off
        wr_pulse(cfgw(3, 1, 1, 0, 1, 0) | cfgw(1, 0, 0, 1, 0, 0));
        check("R2 field positions", rd_p, 32'h0082_8008);
        pins_p[3] = 1'b1;
        cyc(3);
        check("R7 status on third edge", {31'h0, stat_bit(rd_p, 3)}, 32'h1);
        check("R7 irq not yet", {28'h0, irq_p}, 32'h0);
        cyc(1);
        check("R7 irq on fourth edge", {28'h0, irq_p}, 32'h8);
        pins_p[1] = 1'b1;
        cyc(6);
        check("R5 ch1 status set", {31'h0, stat_bit(rd_p, 1)}, 32'h1);
        check("R7 masked ch1 quiet", {28'h0, irq_p}, 32'h8);
        pins_p[3] = 1'b0;
        cyc(4);
        check("R6 level high released", {31'h0, stat_bit(rd_p, 3)}, 32'h0);

        // R9 pulse clear on channel 2, rising
        wr_pulse(cfgw(2, 0, 1, 0, 1, 1));
        check("R9 clear reads one", {31'h0, rd_p[2 + 2*FW]}, 32'h1);
        cyc(1);
        check("R9 clear self resets", {31'h0, rd_p[2 + 2*FW]}, 32'h0);
        pins_p[2] = 1'b1;
        cyc(4);
        check("R3 ch2 irq", {31'h0, irq_p[2]}, 32'h1);
        wr_pulse(cfgw(2, 0, 1, 0, 1, 1));
        cyc(1);
        check("R9 status cleared", {31'h0, stat_bit(rd_p, 2)}, 32'h0);
        cyc(1);
        check("R9 irq dropped", {31'h0, irq_p[2]}, 32'h0);

        // R10 edge meets clear in the same cycle
        pins_p[2] = 1'b0;
        cyc(6);
        pins_p[2] = 1'b1;
        cyc(1);
        wr_pulse(cfgw(2, 0, 1, 0, 1, 1));
        cyc(1);
        check("R10 edge wins over clear", {31'h0, stat_bit(rd_p, 2)}, 32'h1);
        check("R9 clear back to zero", {31'h0, rd_p[2 + 2*FW]}, 32'h0);

        // R11 held clear on the second instance
        wr_held(cfgw(0, 0, 1, 0, 1, 1));
        pins_h[0] = 1'b1;
        cyc(6);
        check("R11 held status stays zero", {31'h0, stat_bit(rd_h, 0)}, 32'h0);
        check("R11 held irq stays zero", {28'h0, irq_h}, 32'h0);
        check("R11 held clear reads one", {31'h0, rd_h[2*FW]}, 32'h1);
        wr_held(cfgw(0, 0, 1, 0, 1, 0));
        cyc(2);
        pins_h[0] = 1'b0;
        cyc(6);
        pins_h[0] = 1'b1;
        cyc(5);
        check("R11 rearmed status", {31'h0, stat_bit(rd_h, 0)}, 32'h1);
        check("R11 rearmed irq", {28'h0, irq_h}, 32'h1);
        wr_held(cfgw(0, 0, 1, 0, 1, 1));
        cyc(1);
        check("R11 clear held drops status", {31'h0, stat_bit(rd_h, 0)}, 32'h0);
        check("R11 clear held drops irq", {28'h0, irq_h}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule